// File: doc/BRIEF.md
# Host-to-DSP Mailbox with Flag Exchange

This block is a register-level mailbox that connects an external byte-wide host bus to the 24-bit register bus of a DSP core. Data travels in both directions through one single-entry slot per direction. On the host side each 24-bit word is presented as three byte registers (high, middle, low). On the core side it is one word. Each side paces itself. It either polls the empty/full bits in its own status register or, on the core side, takes an interrupt request that a per-condition enable gates.

Two general-purpose flag bits travel in each direction. The core writes its pair into its control register, and the host sees that pair read-only in its status register. The host's pair is passed to the core in the same way. Both sides share one clock. Each bus has separate read and write strobes, and read data is combinational from the address.

Top module: `dsp_host_mailbox`

## Requirements
- R1: After reset, host status bit 1 (transmit empty) and core status bit 1 (transmit empty) are 1. Both receive-full bits (bit 0 of each status register) are 0. All flags, interrupt enables and irq_o are 0.
- R2: The host may write the high byte (address 5), the middle byte (address 6) and the low byte (address 7) in any order. The write to address 7 moves {high, middle, low} into the core data register (core address 2). It also sets core status bit 0 and clears host status bit 1.
- R3: A core read of address 2 clears core status bit 0 and sets host status bit 1.
- R4: A core write to address 2 loads the word into the host receive bytes, which read back at addresses 5, 6 and 7 as bits [23:16], [15:8] and [7:0]. The same write clears core status bit 1 and sets host status bit 0.
- R5: A host read of address 7 clears host status bit 0 and sets core status bit 1. Host reads of addresses 5 and 6 change no status.
- R6: A data write into a slot that is still full is dropped. The pending word and the status bits are unchanged, in both directions.
- R7: Core control bits [4:3] appear in host status bits [4:3]. Host control bits [4:3] appear in core status bits [4:3]. Writes to either status register (host address 1, core address 1) have no effect.
- R8: irq_o equals (core control bit 0 AND core status bit 0) OR (core control bit 1 AND core status bit 1).
- R9: Host control (address 0) reads back bits [4:3] with all other bits 0. Core control (address 0) reads back bits [4:3] and [1:0] with all other bits 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_addr_i | input | 3 | Host register address |
| h_wr_i | input | 1 | Host write strobe |
| h_rd_i | input | 1 | Host read strobe |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data, combinational from address |
| c_addr_i | input | 2 | Core register address |
| c_wr_i | input | 1 | Core write strobe |
| c_rd_i | input | 1 | Core read strobe |
| c_wdata_i | input | 24 | Core write data |
| c_rdata_o | output | 24 | Core read data, combinational from address |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Read data is combinational, so a read value is due in the same cycle its address is driven. The bench samples it one time unit after the falling edge that applies the address, before the rising edge that commits any side effect of the read. Every status, flag and interrupt change is due one rising edge after the write or the popping read that causes it. The bench updates its model only after that edge and compares irq_o at the next falling edge. All other results are compared by the next read of the affected register.

// File: rtl/dhm_pkg.sv
package dhm_pkg;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = 3;
  localparam int DATA_W   = BYTE_W * NBYTES;
  localparam int HADDR_W  = 3;
  localparam int CADDR_W  = 2;
  localparam int FLAG_LSB = 3;
  localparam int FLAG_W   = 2;

  localparam logic [HADDR_W-1:0] HA_CTL  = 3'd0;
  localparam logic [HADDR_W-1:0] HA_STAT = 3'd1;
  localparam logic [HADDR_W-1:0] HA_HI   = 3'd5;
  localparam logic [HADDR_W-1:0] HA_MID  = 3'd6;
  localparam logic [HADDR_W-1:0] HA_LO   = 3'd7;

  localparam logic [CADDR_W-1:0] CA_CTL  = 2'd0;
  localparam logic [CADDR_W-1:0] CA_STAT = 2'd1;
  localparam logic [CADDR_W-1:0] CA_DATA = 2'd2;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic              en_txe;
    logic              en_rxf;
  } core_ctl_t;
endpackage

// File: rtl/dhm_slot.sv
module dhm_slot #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (full_o) begin
      if (pop_i) full_o <= 1'b0;   // push while full is dropped
    end else if (push_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
    end
  end

  a_r2_push_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (full_o && data_o == $past(wdata_i)));
  a_r3_pop_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && full_o) |=> !full_o);
  a_r6_full_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(data_o));
endmodule

// File: rtl/dhm_host_if.sv
module dhm_host_if
  import dhm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] h_addr_i,
  input  logic               h_wr_i,
  input  logic               h_rd_i,
  input  logic [BYTE_W-1:0]  h_wdata_i,
  output logic [BYTE_W-1:0]  h_rdata_o,
  input  logic               h2c_full_i,
  output logic               h2c_push_o,
  output logic [DATA_W-1:0]  h2c_word_o,
  input  logic               c2h_full_i,
  input  logic [DATA_W-1:0]  c2h_word_i,
  output logic               c2h_pop_o,
  input  logic [FLAG_W-1:0]  core_flags_i,
  output logic [FLAG_W-1:0]  host_flags_o
);
  logic [BYTE_W-1:0] stage_hi_q, stage_mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_hi_q   <= '0;
      stage_mid_q  <= '0;
      host_flags_o <= '0;
    end else if (h_wr_i) begin
      unique case (h_addr_i)
        HA_CTL: host_flags_o <= h_wdata_i[FLAG_LSB +: FLAG_W];
        HA_HI:  stage_hi_q   <= h_wdata_i;
        HA_MID: stage_mid_q  <= h_wdata_i;
        default: ;
      endcase
    end
  end

  assign h2c_push_o = h_wr_i && (h_addr_i == HA_LO);
  assign h2c_word_o = {stage_hi_q, stage_mid_q, h_wdata_i};
  assign c2h_pop_o  = h_rd_i && (h_addr_i == HA_LO);

  always_comb begin
    h_rdata_o = '0;
    unique case (h_addr_i)
      HA_CTL:  h_rdata_o[FLAG_LSB +: FLAG_W] = host_flags_o;
      HA_STAT: begin
        h_rdata_o[FLAG_LSB +: FLAG_W] = core_flags_i;
        h_rdata_o[1] = !h2c_full_i;
        h_rdata_o[0] = c2h_full_i;
      end
      HA_HI:   h_rdata_o = c2h_word_i[2*BYTE_W +: BYTE_W];
      HA_MID:  h_rdata_o = c2h_word_i[BYTE_W +: BYTE_W];
      HA_LO:   h_rdata_o = c2h_word_i[0 +: BYTE_W];
      default: ;
    endcase
  end

  a_r7_host_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == HA_CTL) |=> (host_flags_o == $past(h_wdata_i[FLAG_LSB +: FLAG_W])));
endmodule

// File: rtl/dhm_core_if.sv
module dhm_core_if
  import dhm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CADDR_W-1:0] c_addr_i,
  input  logic               c_wr_i,
  input  logic               c_rd_i,
  input  logic [DATA_W-1:0]  c_wdata_i,
  output logic [DATA_W-1:0]  c_rdata_o,
  input  logic               h2c_full_i,
  input  logic [DATA_W-1:0]  h2c_word_i,
  output logic               h2c_pop_o,
  input  logic               c2h_full_i,
  output logic               c2h_push_o,
  input  logic [FLAG_W-1:0]  host_flags_i,
  output logic [FLAG_W-1:0]  core_flags_o,
  output logic               irq_o
);
  core_ctl_t ctl_q;
  logic txe, rxf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (c_wr_i && c_addr_i == CA_CTL) begin
      ctl_q.flags  <= c_wdata_i[FLAG_LSB +: FLAG_W];
      ctl_q.en_txe <= c_wdata_i[1];
      ctl_q.en_rxf <= c_wdata_i[0];
    end
  end

  assign txe          = !c2h_full_i;
  assign rxf          = h2c_full_i;
  assign core_flags_o = ctl_q.flags;
  assign c2h_push_o   = c_wr_i && (c_addr_i == CA_DATA);
  assign h2c_pop_o    = c_rd_i && (c_addr_i == CA_DATA);
  assign irq_o        = (ctl_q.en_rxf && rxf) || (ctl_q.en_txe && txe);

  always_comb begin
    c_rdata_o = '0;
    unique case (c_addr_i)
      CA_CTL: begin
        c_rdata_o[FLAG_LSB +: FLAG_W] = ctl_q.flags;
        c_rdata_o[1] = ctl_q.en_txe;
        c_rdata_o[0] = ctl_q.en_rxf;
      end
      CA_STAT: begin
        c_rdata_o[FLAG_LSB +: FLAG_W] = host_flags_i;
        c_rdata_o[1] = txe;
        c_rdata_o[0] = rxf;
      end
      CA_DATA: c_rdata_o = h2c_word_i;
      default: ;
    endcase
  end

  a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_q.en_rxf || ctl_q.en_txe));
  a_r7_core_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr_i && c_addr_i == CA_CTL) |=> (core_flags_o == $past(c_wdata_i[FLAG_LSB +: FLAG_W])));
endmodule

// File: rtl/dsp_host_mailbox.sv
module dsp_host_mailbox
  import dhm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] h_addr_i,
  input  logic               h_wr_i,
  input  logic               h_rd_i,
  input  logic [BYTE_W-1:0]  h_wdata_i,
  output logic [BYTE_W-1:0]  h_rdata_o,
  input  logic [CADDR_W-1:0] c_addr_i,
  input  logic               c_wr_i,
  input  logic               c_rd_i,
  input  logic [DATA_W-1:0]  c_wdata_i,
  output logic [DATA_W-1:0]  c_rdata_o,
  output logic               irq_o
);
  logic              h2c_push, h2c_pop, h2c_full;
  logic              c2h_push, c2h_pop, c2h_full;
  logic [DATA_W-1:0] h2c_in, h2c_word, c2h_word;
  logic [FLAG_W-1:0] host_flags, core_flags;

  dhm_slot #(.W(DATA_W)) u_h2c (
    .clk_i, .rst_ni, .push_i(h2c_push), .pop_i(h2c_pop),
    .wdata_i(h2c_in), .data_o(h2c_word), .full_o(h2c_full));

  dhm_slot #(.W(DATA_W)) u_c2h (
    .clk_i, .rst_ni, .push_i(c2h_push), .pop_i(c2h_pop),
    .wdata_i(c_wdata_i), .data_o(c2h_word), .full_o(c2h_full));

  dhm_host_if u_host (
    .clk_i, .rst_ni, .h_addr_i, .h_wr_i, .h_rd_i, .h_wdata_i, .h_rdata_o,
    .h2c_full_i(h2c_full), .h2c_push_o(h2c_push), .h2c_word_o(h2c_in),
    .c2h_full_i(c2h_full), .c2h_word_i(c2h_word), .c2h_pop_o(c2h_pop),
    .core_flags_i(core_flags), .host_flags_o(host_flags));

  dhm_core_if u_core (
    .clk_i, .rst_ni, .c_addr_i, .c_wr_i, .c_rd_i, .c_wdata_i, .c_rdata_o,
    .h2c_full_i(h2c_full), .h2c_word_i(h2c_word), .h2c_pop_o(h2c_pop),
    .c2h_full_i(c2h_full), .c2h_push_o(c2h_push),
    .host_flags_i(host_flags), .core_flags_o(core_flags), .irq_o);

  a_r5_host_pop_frees_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_rd_i && h_addr_i == HA_LO && c2h_full) |=> !c2h_full);
  a_r1_reset_status: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!h2c_full && !c2h_full && !irq_o));
endmodule

// File: tb/dsp_host_mailbox_tb.sv
`timescale 1ns/1ps
module dsp_host_mailbox_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0, h_rdata;
  logic [1:0]  c_addr = '0;
  logic        c_wr = 1'b0, c_rd = 1'b0;
  logic [23:0] c_wdata = '0, c_rdata;
  logic        irq;

  always #4 clk = ~clk;

  dsp_host_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_addr_i(h_addr), .h_wr_i(h_wr), .h_rd_i(h_rd), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .c_addr_i(c_addr), .c_wr_i(c_wr), .c_rd_i(c_rd), .c_wdata_i(c_wdata), .c_rdata_o(c_rdata),
    .irq_o(irq));

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  bit          m_h2c_full, m_c2h_full;
  logic [23:0] m_h2c_word, m_c2h_word;
  logic [7:0]  m_hi, m_mid;
  logic [1:0]  m_hflags, m_cflags, m_cen;

  task automatic chk(string tag, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_h(logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_hflags, 3'b0};
      3'd1: return {3'b0, m_cflags, 1'b0, !m_h2c_full, m_c2h_full};
      3'd5: return m_c2h_word[23:16];
      3'd6: return m_c2h_word[15:8];
      3'd7: return m_c2h_word[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [23:0] exp_c(logic [1:0] a);
    case (a)
      2'd0: return {19'b0, m_cflags, 1'b0, m_cen};
      2'd1: return {19'b0, m_hflags, 1'b0, !m_c2h_full, m_h2c_full};
      2'd2: return m_h2c_word;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_cen[0] && m_h2c_full) || (m_cen[1] && !m_c2h_full);
  endfunction

  task automatic chk_irq();
    chk("R8 irq", {23'b0, irq}, {23'b0, exp_irq()});
  endtask

  task automatic hw(logic [2:0] a, logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
    case (a)
      3'd0: m_hflags = d[4:3];
      3'd5: m_hi = d;
      3'd6: m_mid = d;
      3'd7: if (!m_h2c_full) begin m_h2c_word = {m_hi, m_mid, d}; m_h2c_full = 1; end
      default: ;
    endcase
    chk_irq();
  endtask

  task automatic hr(logic [2:0] a, string tag);
    @(negedge clk); h_addr = a; h_rd = 1'b1; #1;
    chk(tag, {16'b0, h_rdata}, {16'b0, exp_h(a)});
    @(negedge clk); h_rd = 1'b0;
    if (a == 3'd7) m_c2h_full = 0;
    chk_irq();
  endtask

  task automatic cw(logic [1:0] a, logic [23:0] d);
    @(negedge clk); c_addr = a; c_wdata = d; c_wr = 1'b1;
    @(negedge clk); c_wr = 1'b0;
    case (a)
      2'd0: begin m_cen = d[1:0]; m_cflags = d[4:3]; end
      2'd2: if (!m_c2h_full) begin m_c2h_word = d; m_c2h_full = 1; end
      default: ;
    endcase
    chk_irq();
  endtask

  task automatic cr(logic [1:0] a, string tag);
    @(negedge clk); c_addr = a; c_rd = 1'b1; #1;
    chk(tag, c_rdata, exp_c(a));
    @(negedge clk); c_rd = 1'b0;
    if (a == 2'd2) m_h2c_full = 0;
    chk_irq();
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_h2c_full = 0; m_c2h_full = 0; m_h2c_word = '0; m_c2h_word = '0;
    m_hi = '0; m_mid = '0; m_hflags = '0; m_cflags = '0; m_cen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq();
    hr(3'd1, "R1 host status");
    cr(2'd1, "R1 core status");
    hr(3'd0, "R1 host ctl");
    cr(2'd0, "R1 core ctl");
    // R2 host to core word
    hw(3'd5, 8'hAB); hw(3'd6, 8'hCD); hw(3'd7, 8'hEF);
    cr(2'd1, "R2 core rxf");
    hr(3'd1, "R2 host txe cleared");
    // R6 drop on full
    hw(3'd5, 8'h11); hw(3'd6, 8'h22); hw(3'd7, 8'h33);
    cr(2'd2, "R2 R6 core data and pop");
    cr(2'd1, "R3 core rxf cleared");
    hr(3'd1, "R3 host txe set");
    // R4/R5 core to host
    cw(2'd2, 24'h123456);
    cw(2'd2, 24'h999999);
    hr(3'd1, "R4 host rxf");
    cr(2'd1, "R4 core txe cleared");
    hr(3'd5, "R4 hi"); hr(3'd6, "R4 R6 mid");
    hr(3'd1, "R5 hi/mid no pop");
    hr(3'd7, "R4 lo");
    hr(3'd1, "R5 host rxf cleared");
    cr(2'd1, "R5 core txe set");
    // R7 flags, status write ignored
    cw(2'd0, 24'h000018); hw(3'd0, 8'h08);
    hr(3'd1, "R7 core flags at host");
    cr(2'd1, "R7 host flags at core");
    hw(3'd1, 8'hFF); cw(2'd1, 24'hFFFFFF);
    hr(3'd1, "R7 host status write ignored");
    cr(2'd1, "R7 core status write ignored");
    // R8 irq with enables, R9 readback masks
    cw(2'd0, 24'hFFFFFF); cr(2'd0, "R9 core ctl mask");
    hw(3'd0, 8'hFF); hr(3'd0, "R9 host ctl mask");
    hr(3'd3, "R9 host unmapped"); cr(2'd3, "R9 core unmapped");
    hw(3'd7, 8'h5A); cw(2'd0, 24'h1);
    cw(2'd0, 24'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      automatic int op = $urandom_range(0, 5);
      automatic logic [2:0] ha = 3'($urandom_range(0, 7));
      automatic logic [1:0] ca = 2'($urandom_range(0, 3));
      case (op)
        0, 1: hw(ha, 8'($urandom));
        2:    hr(ha, "R2-random host read");
        3:    cw(ca, 24'($urandom));
        default: cr(ca, "R3-random core read");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule